// File: doc/BRIEF.md
# I2C Controller Control Register Block

This block holds the single 8-bit control register of a multi-master I2C controller. It sits on a simple CPU bus made of an address, a write strobe, a read strobe, write data and registered read data. From the register it drives the controller's static controls: module enable, interrupt enable, acknowledge suppression and the packet-error-check byte marker. It also produces a repeated-start request for the bit-level bus engine.

The block keeps the bus-busy flag and four sticky event flags: transmit done, receive done, arbitration lost and no acknowledge. It merges the event flags into one interrupt request. While the module is switched off it holds every flag at zero.

The bus engine itself is not part of this block. Its behaviour reaches the block through input strobes: START and STOP detection, repeated START completion, master mode being dropped, and event set and clear pulses. The CPU bus carries no stream traffic. Every pin is a plain control or status signal, so there is no valid/ready handshake and no back-pressure.

Top module: `i2c_ctrl_regs`

## Requirements
- R1: After reset, every control output, the busy flag, all event flags, the interrupt request and the read data are 0.
- R2: A read strobe at REG_ADDR returns, on the next clock, the byte {enable b7, interrupt enable b6, 0 b5, 0 b4, ack-disable b3, repeated-start enable b2, PEC byte b1, 0 b0}. A write at REG_ADDR takes effect at the clock where it is sampled. When no read is addressed to the register, the read data returns to 0.
- R3: A read at any other address returns 0. A write at any other address changes nothing.
- R4: While the enable bit is 0, the busy flag and all event flags become 0 at the next clock, and event and START strobes have no effect.
- R5: While enabled, a START strobe sets the busy flag. A STOP strobe clears it, and so does a register write with bit 5 = 1. When a clear and a START arrive in the same cycle, the clear wins. Writing bit 5 = 0 leaves busy unchanged.
- R6: Event flag k (0 transmit done, 1 receive done, 2 arbitration lost, 3 no acknowledge) is set by ev_set_i[k] while enabled and cleared by ev_clr_i[k]. When both arrive in the same cycle, the set wins.
- R7: irq_o is 1 exactly when interrupt enable is 1 and at least one event flag is 1.
- R8: The repeated-start enable is cleared by a repeated-START-done strobe or by a master-mode-cleared strobe. Either clear overrides a CPU write in the same cycle.
- R9: rs_req_o is 1 exactly when master_mode_i is 1 and the repeated-start enable is 1.
- R10: ack_dis_o and pec_byte_o follow register bits 3 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | CPU bus address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| master_mode_i | input | 1 | Engine is in master mode |
| mast_clr_i | input | 1 | Pulse: master mode was dropped |
| rs_done_i | input | 1 | Pulse: repeated START completed |
| start_det_i | input | 1 | Pulse: START seen on the bus |
| stop_det_i | input | 1 | Pulse: STOP seen on the bus |
| ev_set_i | input | NUM_EV | Per-flag event set pulses |
| ev_clr_i | input | NUM_EV | Per-flag clear pulses |
| en_o | output | 1 | Module enable |
| ien_o | output | 1 | Interrupt enable |
| ack_dis_o | output | 1 | Suppress acknowledge on received bytes |
| pec_byte_o | output | 1 | Next received byte is the PEC byte |
| rs_req_o | output | 1 | Repeated START request to the engine |
| busy_o | output | 1 | Bus-busy flag |
| flags_o | output | NUM_EV | Event flags |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that every engine strobe and bus strobe is a clean synchronous level, sampled at the rising edge and settled before it. They also assume that a read and a write in the same cycle are legal but independent. The bench changes all inputs on the falling edge and holds each pulse for exactly one clock. It deliberately stacks conflicting strobes in the same cycle (a clear with a START, a set with a clear, a write with a repeated-start clear), so that every priority rule is exercised within those assumptions.

// File: rtl/i2c_ctrl_pkg.sv
package i2c_ctrl_pkg;
  // Bit positions decoded by software and by the register block
  localparam int BIT_EN      = 7;
  localparam int BIT_IEN     = 6;
  localparam int BIT_CLRBUSY = 5;
  localparam int BIT_ACKDIS  = 3;
  localparam int BIT_RSEN    = 2;
  localparam int BIT_PEC     = 1;

  typedef struct packed {
    logic en;
    logic ien;
    logic ack_dis;
    logic rs_en;
    logic pec;
  } ctrl_t;

  function automatic logic [7:0] pack_ctrl(ctrl_t c);
    logic [7:0] v;
    v              = 8'h00;
    v[BIT_EN]      = c.en;
    v[BIT_IEN]     = c.ien;
    v[BIT_ACKDIS]  = c.ack_dis;
    v[BIT_RSEN]    = c.rs_en;
    v[BIT_PEC]     = c.pec;
    return v;
  endfunction
endpackage

// File: rtl/i2c_ctrl_bits.sv
module i2c_ctrl_bits
  import i2c_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_hit_i,
  input  logic [7:0] wdata_i,
  input  logic       rs_done_i,
  input  logic       mast_clr_i,
  output ctrl_t      ctrl_o
);
  ctrl_t ctrl_q;
  logic  hw_rs_clr;

  assign hw_rs_clr = rs_done_i | mast_clr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else begin
      if (wr_hit_i) begin
        ctrl_q.en      <= wdata_i[BIT_EN];
        ctrl_q.ien     <= wdata_i[BIT_IEN];
        ctrl_q.ack_dis <= wdata_i[BIT_ACKDIS];
        ctrl_q.pec     <= wdata_i[BIT_PEC];
      end
      // hardware clear overrides the CPU value
      if (hw_rs_clr)
        ctrl_q.rs_en <= 1'b0;
      else if (wr_hit_i)
        ctrl_q.rs_en <= wdata_i[BIT_RSEN];
    end
  end

  assign ctrl_o = ctrl_q;

  // R8
  rs_hw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_done_i || mast_clr_i) |=> !ctrl_o.rs_en);

  // R10
  write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit_i |=> (ctrl_o.ack_dis == $past(wdata_i[BIT_ACKDIS]))
                 && (ctrl_o.pec == $past(wdata_i[BIT_PEC])));
endmodule

// File: rtl/i2c_ctrl_flags.sv
module i2c_ctrl_flags #(
  parameter int NUM_EV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              clr_busy_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [NUM_EV-1:0] ev_set_i,
  input  logic [NUM_EV-1:0] ev_clr_i,
  output logic              busy_o,
  output logic [NUM_EV-1:0] flags_o
);
  logic              busy_q;
  logic [NUM_EV-1:0] flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  busy_q <= 1'b0;
    else if (!en_i)              busy_q <= 1'b0;
    else if (clr_busy_i || stop_i) busy_q <= 1'b0;
    else if (start_i)            busy_q <= 1'b1;
  end

  for (genvar g = 0; g < NUM_EV; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           flag_q[g] <= 1'b0;
      else if (!en_i)       flag_q[g] <= 1'b0;
      else if (ev_set_i[g]) flag_q[g] <= 1'b1;
      else if (ev_clr_i[g]) flag_q[g] <= 1'b0;
    end
  end

  assign busy_o  = busy_q;
  assign flags_o = flag_q;

  // R4
  off_holds_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (flags_o == '0) && !busy_o);

  // R5
  busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_busy_i || stop_i) |=> !busy_o);

  // R5
  busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && start_i && !clr_busy_i && !stop_i) |=> busy_o);

  // R6
  ev_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> ((flags_o & $past(ev_set_i)) == $past(ev_set_i)));
endmodule

// File: rtl/i2c_ctrl_irq.sv
module i2c_ctrl_irq #(
  parameter int NUM_EV = 4
) (
  input  logic              ien_i,
  input  logic [NUM_EV-1:0] flags_i,
  output logic              irq_o
);
  assign irq_o = ien_i & (|flags_i);
endmodule

// File: rtl/i2c_ctrl_regs.sv
module i2c_ctrl_regs
  import i2c_ctrl_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h20,
  parameter int              NUM_EV   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              master_mode_i,
  input  logic              mast_clr_i,
  input  logic              rs_done_i,
  input  logic              start_det_i,
  input  logic              stop_det_i,
  input  logic [NUM_EV-1:0] ev_set_i,
  input  logic [NUM_EV-1:0] ev_clr_i,
  output logic              en_o,
  output logic              ien_o,
  output logic              ack_dis_o,
  output logic              pec_byte_o,
  output logic              rs_req_o,
  output logic              busy_o,
  output logic [NUM_EV-1:0] flags_o,
  output logic              irq_o
);
  logic       addr_hit, wr_hit, rd_hit, clr_busy;
  ctrl_t      ctrl;
  logic [7:0] rdata_q;

  assign addr_hit = (bus_addr == REG_ADDR);
  assign wr_hit   = bus_wr & addr_hit;
  assign rd_hit   = bus_rd & addr_hit;
  assign clr_busy = wr_hit & bus_wdata[BIT_CLRBUSY];

  i2c_ctrl_bits u_bits (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_hit_i   (wr_hit),
    .wdata_i    (bus_wdata),
    .rs_done_i  (rs_done_i),
    .mast_clr_i (mast_clr_i),
    .ctrl_o     (ctrl)
  );

  i2c_ctrl_flags #(.NUM_EV(NUM_EV)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (ctrl.en),
    .clr_busy_i (clr_busy),
    .start_i    (start_det_i),
    .stop_i     (stop_det_i),
    .ev_set_i   (ev_set_i),
    .ev_clr_i   (ev_clr_i),
    .busy_o     (busy_o),
    .flags_o    (flags_o)
  );

  i2c_ctrl_irq #(.NUM_EV(NUM_EV)) u_irq (
    .ien_i   (ctrl.ien),
    .flags_i (flags_o),
    .irq_o   (irq_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= 8'h00;
    else if (rd_hit) rdata_q <= pack_ctrl(ctrl);
    else             rdata_q <= 8'h00;
  end

  assign bus_rdata  = rdata_q;
  assign en_o       = ctrl.en;
  assign ien_o      = ctrl.ien;
  assign ack_dis_o  = ctrl.ack_dis;
  assign pec_byte_o = ctrl.pec;
  assign rs_req_o   = master_mode_i & ctrl.rs_en;

  // R2
  unimpl_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata[5:4] == 2'b00) && !bus_rdata[0]);

  // R3
  miss_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !addr_hit) |=> (bus_rdata == 8'h00));

  // R7
  irq_needs_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (ien_o && (flags_o != '0)));
endmodule

// File: tb/tb_i2c_ctrl_regs.sv
module tb_i2c_ctrl_regs;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] REG = 8'h20;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_rdata;
  logic       master_mode_i = 1'b0, mast_clr_i = 1'b0, rs_done_i = 1'b0;
  logic       start_det_i = 1'b0, stop_det_i = 1'b0;
  logic [3:0] ev_set_i = 4'h0, ev_clr_i = 4'h0;
  logic       en_o, ien_o, ack_dis_o, pec_byte_o, rs_req_o, busy_o, irq_o;
  logic [3:0] flags_o;

  int checks = 0, errors = 0;
  bit done = 0;

  i2c_ctrl_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .master_mode_i(master_mode_i),
    .mast_clr_i(mast_clr_i), .rs_done_i(rs_done_i), .start_det_i(start_det_i),
    .stop_det_i(stop_det_i), .ev_set_i(ev_set_i), .ev_clr_i(ev_clr_i),
    .en_o(en_o), .ien_o(ien_o), .ack_dis_o(ack_dis_o), .pec_byte_o(pec_byte_o),
    .rs_req_o(rs_req_o), .busy_o(busy_o), .flags_o(flags_o), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference state
  bit       m_en, m_ien, m_ack, m_rs, m_pec, m_busy;
  bit [3:0] m_flags;
  bit [7:0] m_rdata;

  always @(posedge clk) begin
    bit hit_w, hit_r;
    bit [7:0] rd_val;
    if (!rst_n) begin
      m_en = 0; m_ien = 0; m_ack = 0; m_rs = 0; m_pec = 0;
      m_busy = 0; m_flags = 0; m_rdata = 0;
    end else begin
      hit_w  = bus_wr && (bus_addr == REG);
      hit_r  = bus_rd && (bus_addr == REG);
      rd_val = {m_en, m_ien, 2'b00, m_ack, m_rs, m_pec, 1'b0};
      m_rdata = hit_r ? rd_val : 8'h00;
      if (!m_en) begin
        m_busy = 0; m_flags = 0;
      end else begin
        if (stop_det_i || (hit_w && bus_wdata[5])) m_busy = 0;
        else if (start_det_i) m_busy = 1;
        for (int k = 0; k < 4; k++)
          if (ev_set_i[k]) m_flags[k] = 1;
          else if (ev_clr_i[k]) m_flags[k] = 0;
      end
      if (hit_w) begin
        m_en = bus_wdata[7]; m_ien = bus_wdata[6];
        m_ack = bus_wdata[3]; m_pec = bus_wdata[1]; m_rs = bus_wdata[2];
      end
      if (rs_done_i || mast_clr_i) m_rs = 0;
    end
  end

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // Per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 rdata", bus_rdata, m_rdata);
      chk("R2 en", en_o, m_en);
      chk("R2 ien", ien_o, m_ien);
      chk("R10 ack", ack_dis_o, m_ack);
      chk("R10 pec", pec_byte_o, m_pec);
      chk("R9 rs_req", rs_req_o, m_rs & master_mode_i);
      chk("R5 busy", busy_o, m_busy);
      chk("R6 flags", flags_o, m_flags);
      chk("R7 irq", irq_o, m_ien & (|m_flags));
    end
  end

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    idle(2); rst_n = 1; idle(1);
    // R1 reset state
    chk("R1", {en_o, ien_o, ack_dis_o, pec_byte_o, rs_req_o, busy_o, irq_o}, 0);
    chk("R1", flags_o, 0);
    rd(REG); chk("R1", bus_rdata, 8'h00);

    // R2 write all ones, read layout
    wr(REG, 8'hFF); rd(REG); chk("R2", bus_rdata, 8'hCE);
    idle(1); chk("R2", bus_rdata, 8'h00);

    // R3 other address
    wr(8'h21, 8'h00); rd(REG); chk("R3", bus_rdata, 8'hCE);
    rd(8'h21); chk("R3", bus_rdata, 8'h00);

    // R5 busy
    @(negedge clk); start_det_i = 1; @(negedge clk); start_det_i = 0;
    chk("R5", busy_o, 1);
    wr(REG, 8'hCA); chk("R5", busy_o, 1);
    wr(REG, 8'hEA); chk("R5", busy_o, 0);
    @(negedge clk); start_det_i = 1; @(negedge clk); start_det_i = 0;
    @(negedge clk); stop_det_i = 1; @(negedge clk); stop_det_i = 0;
    chk("R5", busy_o, 0);
    @(negedge clk); start_det_i = 1; stop_det_i = 1;
    @(negedge clk); start_det_i = 0; stop_det_i = 0;
    chk("R5", busy_o, 0);

    // R6 / R7 flags and interrupt
    @(negedge clk); ev_set_i = 4'b0001; @(negedge clk); ev_set_i = 0;
    chk("R6", flags_o, 4'b0001); chk("R7", irq_o, 1);
    wr(REG, 8'h80); chk("R7", irq_o, 0); chk("R6", flags_o, 4'b0001);
    @(negedge clk); ev_set_i = 4'b1000; ev_clr_i = 4'b1001;
    @(negedge clk); ev_set_i = 0; ev_clr_i = 0;
    chk("R6", flags_o, 4'b1000);
    wr(REG, 8'hC0); chk("R7", irq_o, 1);
    @(negedge clk); ev_set_i = 4'b0110; @(negedge clk); ev_set_i = 0;
    chk("R6", flags_o, 4'b1110);

    // R4 disable
    @(negedge clk); start_det_i = 1; @(negedge clk); start_det_i = 0;
    wr(REG, 8'h40); chk("R4", flags_o, 4'b1110);
    idle(1); chk("R4", flags_o, 0); chk("R4", busy_o, 0); chk("R7", irq_o, 0);
    @(negedge clk); ev_set_i = 4'hF; start_det_i = 1;
    @(negedge clk); ev_set_i = 0; start_det_i = 0;
    chk("R4", flags_o, 0); chk("R4", busy_o, 0);

    // R8 / R9 repeated start
    master_mode_i = 1;
    wr(REG, 8'h84); chk("R9", rs_req_o, 1);
    @(negedge clk); master_mode_i = 0; #1 chk("R9", rs_req_o, 0);
    rd(REG); chk("R9", bus_rdata, 8'h84);
    master_mode_i = 1;
    @(negedge clk); rs_done_i = 1; @(negedge clk); rs_done_i = 0;
    chk("R8", rs_req_o, 0);
    wr(REG, 8'h84);
    @(negedge clk); mast_clr_i = 1; master_mode_i = 0; @(negedge clk); mast_clr_i = 0;
    rd(REG); chk("R8", bus_rdata, 8'h80);
    @(negedge clk); bus_wr = 1; bus_addr = REG; bus_wdata = 8'h84; rs_done_i = 1;
    @(negedge clk); bus_wr = 0; rs_done_i = 0;
    rd(REG); chk("R8", bus_rdata, 8'h80);

    // R10 ack/pec
    wr(REG, 8'h8A); chk("R10", ack_dis_o, 1); chk("R10", pec_byte_o, 1);
    wr(REG, 8'h80); chk("R10", ack_dis_o, 0); chk("R10", pec_byte_o, 0);

    idle(3);
    summary();
    $finish;
  end
endmodule